// File: doc/BRIEF.md
# Banked Breakpoint Comparator Register Window

This block keeps the match addresses of three hardware breakpoint comparators and makes them visible to software through one small byte-wide register window. The comparators are called A, B and C. A control register holds a 2-bit bank select. Only the comparator named by the bank select can be seen in the window. One select code names no comparator at all, and that code leaves the window empty.

Software reads and writes the window with single-byte accesses. Reads are allowed at any time. Writes to the comparator address registers are dropped while the debug logic is armed. The bank select itself can be written at any time.

The block also watches the CPU address bus. For every comparator whose 18-bit stored address equals the address of a valid bus access, it raises a one-cycle match pulse.

Top module: `dbg_cmp_window`

## Requirements
- R1: After reset, every comparator address bit is 0, the bank select is 00, `reg_rdata_o` is 0 and `match_o` is 0.
- R2: The control register sits at offset 0x20. Bits 1:0 hold the bank select and can be written at any time, armed or not. Bits 7:2 read as 0.
- R3: The bank select picks the comparator shown at offsets 0x29–0x2B. Reads and writes there reach comparator A for 00, B for 01 and C for 10.
- R4: With bank select 11, reads of offsets 0x29–0x2B return 0, and writes there change no comparator.
- R5: Offset 0x29 holds only address bits 17:16, in data bits 1:0. Data bits 7:2 read as 0, and written values in those bits are dropped.
- R6: Offset 0x2A holds address bits 15:8. Offset 0x2B holds address bits 7:0.
- R7: A write to offsets 0x29–0x2B while `armed_i` is 1 leaves every comparator unchanged. No error is signalled.
- R8: Offsets 0x28 and 0x2C–0x2F, and all other offsets except 0x20, read as 0. Writes to them change nothing.
- R9: Read data appears on `reg_rdata_o` one cycle after the read access. It stays unchanged until the next read.
- R10: `match_o[i]` is 1 in the cycle after a valid CPU access whose address equals every bit of comparator i's stored address. Index 0 is A, 1 is B and 2 is C. Several bits can be 1 at once. A single access gives a one-cycle pulse.
- R11: `match_o` stays 0 in the cycle after a cycle in which `cpu_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| armed_i | input | 1 | Debug logic armed; blocks comparator register writes |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| cpu_valid_i | input | 1 | CPU bus access valid |
| cpu_addr_i | input | 18 | CPU bus address |
| match_o | output | 3 | Per-comparator match pulse (0=A, 1=B, 2=C) |

## Verification
Suppose a comparator register picks up a wrong value, for example from a write that slipped past the armed lock, a write that went to the wrong bank, or stray high bits. That fault stays hidden until the register is read back through the window or the CPU bus presents that address. The reference model compares `reg_rdata_o` and `match_o` on every cycle. Because of that, the fault shows up one cycle after the next read or bus access that touches it. A wrong bank select shows up on the very next window read, as data from the wrong comparator or as nonzero data in the empty bank.

// File: rtl/dbg_win_pkg.sv
package dbg_win_pkg;
  localparam int OFS_CTL = 'h20;
  localparam int OFS_HI  = 'h29;
  localparam int OFS_MID = 'h2A;
  localparam int OFS_LOW = 'h2B;

  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_HI   = 2'd1,
    FLD_MID  = 2'd2,
    FLD_LOW  = 2'd3
  } fld_e;
endpackage

// File: rtl/dbg_win_decode.sv
module dbg_win_decode
  import dbg_win_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  output logic              ctl_wr_o,
  output logic              cmp_wr_o,
  output logic              rd_o,
  output logic              ctl_sel_o,
  output fld_e              fld_o
);
  always_comb begin
    unique case (int'(reg_addr_i))
      OFS_HI:  fld_o = FLD_HI;
      OFS_MID: fld_o = FLD_MID;
      OFS_LOW: fld_o = FLD_LOW;
      default: fld_o = FLD_NONE;
    endcase
  end

  assign ctl_sel_o = (int'(reg_addr_i) == OFS_CTL);
  assign ctl_wr_o  = reg_en_i && reg_we_i && ctl_sel_o;
  assign cmp_wr_o  = reg_en_i && reg_we_i && (fld_o != FLD_NONE);
  assign rd_o      = reg_en_i && !reg_we_i;
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_win_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int CMP_AW  = 18,
  parameter int SEL_W   = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            armed_i,
  input  logic                            wr_i,
  input  logic [SEL_W-1:0]                wr_idx_i,
  input  fld_e                            fld_i,
  input  logic [7:0]                      wdata_i,
  output logic [NUM_CMP-1:0][CMP_AW-1:0]  cmp_addr_o
);
  localparam int HI_W = CMP_AW - 16;

  logic wr_ok;
  assign wr_ok = wr_i && !armed_i;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic hit;
    assign hit = wr_ok && (wr_idx_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_addr_o[g] <= '0;
      end else if (hit) begin
        case (fld_i)
          FLD_HI:  cmp_addr_o[g][CMP_AW-1:16] <= wdata_i[HI_W-1:0];
          FLD_MID: cmp_addr_o[g][15:8]        <= wdata_i;
          FLD_LOW: cmp_addr_o[g][7:0]         <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  AST_ARMED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> $stable(cmp_addr_o)); // R7

  AST_EMPTY_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(wr_idx_i) >= NUM_CMP) |=> $stable(cmp_addr_o)); // R4
endmodule

// File: rtl/dbg_cmp_match.sv
module dbg_cmp_match #(
  parameter int NUM_CMP = 3,
  parameter int CMP_AW  = 18
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cpu_valid_i,
  input  logic [CMP_AW-1:0]               cpu_addr_i,
  input  logic [NUM_CMP-1:0][CMP_AW-1:0]  cmp_addr_i,
  output logic [NUM_CMP-1:0]              match_o
);
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_m
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_o[g] <= 1'b0;
      else         match_o[g] <= cpu_valid_i && (cpu_addr_i == cmp_addr_i[g]);
    end
  end

  AST_MATCH_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_valid_i |=> (match_o == '0)); // R11
endmodule

// File: rtl/dbg_cmp_window.sv
module dbg_cmp_window
  import dbg_win_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int CMP_AW  = 18,
  parameter int REG_AW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              cpu_valid_i,
  input  logic [CMP_AW-1:0] cpu_addr_i,
  output logic [NUM_CMP-1:0] match_o
);
  localparam int SEL_W = $clog2(NUM_CMP + 1);
  localparam int HI_W  = CMP_AW - 16;

  logic ctl_wr, cmp_wr, rd, ctl_sel;
  fld_e fld;
  logic [SEL_W-1:0] sel_q;
  logic [NUM_CMP-1:0][CMP_AW-1:0] cmp_addr;
  logic [CMP_AW-1:0] vis_addr;
  logic              vis_ok;
  logic [7:0]        rd_next;

  dbg_win_decode #(.REG_AW(REG_AW)) u_dec (
    .reg_en_i   (reg_en_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .ctl_wr_o   (ctl_wr),
    .cmp_wr_o   (cmp_wr),
    .rd_o       (rd),
    .ctl_sel_o  (ctl_sel),
    .fld_o      (fld)
  );

  // bank select; writable regardless of armed state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (ctl_wr) sel_q <= reg_wdata_i[SEL_W-1:0];
  end

  dbg_cmp_bank #(.NUM_CMP(NUM_CMP), .CMP_AW(CMP_AW), .SEL_W(SEL_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .armed_i    (armed_i),
    .wr_i       (cmp_wr),
    .wr_idx_i   (sel_q),
    .fld_i      (fld),
    .wdata_i    (reg_wdata_i),
    .cmp_addr_o (cmp_addr)
  );

  dbg_cmp_match #(.NUM_CMP(NUM_CMP), .CMP_AW(CMP_AW)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_valid_i (cpu_valid_i),
    .cpu_addr_i  (cpu_addr_i),
    .cmp_addr_i  (cmp_addr),
    .match_o     (match_o)
  );

  always_comb begin
    vis_addr = '0;
    vis_ok   = 1'b0;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (sel_q == SEL_W'(i)) begin
        vis_addr = cmp_addr[i];
        vis_ok   = 1'b1;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (ctl_sel) begin
      rd_next[SEL_W-1:0] = sel_q;
    end else if (vis_ok) begin
      case (fld)
        FLD_HI:  rd_next[HI_W-1:0] = vis_addr[CMP_AW-1:16];
        FLD_MID: rd_next = vis_addr[15:8];
        FLD_LOW: rd_next = vis_addr[7:0];
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  reg_rdata_o <= '0;
    else if (rd)  reg_rdata_o <= rd_next;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(reg_rdata_o)); // R9

  AST_HI_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && int'(reg_addr_i) == OFS_HI) |=> (reg_rdata_o[7:HI_W] == '0)); // R5

  AST_CTL_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && int'(reg_addr_i) == OFS_CTL) |=> (reg_rdata_o[7:SEL_W] == '0)); // R2

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && int'(sel_q) >= NUM_CMP && int'(reg_addr_i) != OFS_CTL)
      |=> (reg_rdata_o == '0)); // R4
endmodule

// File: tb/tb_dbg_cmp_window.sv
module tb_dbg_cmp_window;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        armed = 0;
  logic        en = 0, we = 0;
  logic [7:0]  addr = 0, wdata = 0;
  logic [7:0]  rdata;
  logic        cpu_valid = 0;
  logic [17:0] cpu_addr = 0;
  logic [2:0]  match;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dbg_cmp_window dut (
    .clk_i(clk), .rst_ni(rst_n), .armed_i(armed),
    .reg_en_i(en), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cpu_valid_i(cpu_valid), .cpu_addr_i(cpu_addr),
    .match_o(match)
  );

  // behavioural reference model
  logic [17:0] m_addr [3];
  logic [1:0]  m_sel;
  logic [7:0]  m_rd;
  logic [2:0]  m_match;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a == 8'h20) return {6'b0, m_sel};
    if (m_sel == 2'b11) return 8'h00;
    case (a)
      8'h29: return {6'b0, m_addr[m_sel][17:16]};
      8'h2A: return m_addr[m_sel][15:8];
      8'h2B: return m_addr[m_sel][7:0];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_addr[i] <= '0;
      m_sel <= 0; m_rd <= 0; m_match <= 0;
    end else begin
      for (int i = 0; i < 3; i++) m_match[i] <= cpu_valid && (cpu_addr == m_addr[i]);
      if (en && !we) m_rd <= model_read(addr);
      if (en && we) begin
        if (addr == 8'h20) m_sel <= wdata[1:0];
        else if (!armed && m_sel != 2'b11) begin
          case (addr)
            8'h29: m_addr[m_sel][17:16] <= wdata[1:0];
            8'h2A: m_addr[m_sel][15:8]  <= wdata;
            8'h2B: m_addr[m_sel][7:0]   <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 rdata vs model", rdata, m_rd);
      chk("R10 match vs model", match, m_match);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2; en = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #2; en = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(posedge clk); #2; en = 1; we = 0; addr = a;
    @(posedge clk); #2; en = 0; d = rdata;
  endtask

  task automatic cpu(input logic [17:0] a, input logic v, output logic [2:0] m);
    @(posedge clk); #2; cpu_valid = v; cpu_addr = a;
    @(posedge clk); #2; cpu_valid = 0; m = match;
  endtask

  task automatic set_cmp(input logic [1:0] s, input logic [17:0] v);
    bus_wr(8'h20, {6'b0, s});
    bus_wr(8'h29, {6'b111111, v[17:16]});
    bus_wr(8'h2A, v[15:8]);
    bus_wr(8'h2B, v[7:0]);
  endtask

  task automatic get_cmp(input logic [1:0] s, output logic [17:0] v);
    logic [7:0] h, mm, l;
    bus_wr(8'h20, {6'b0, s});
    bus_rd(8'h29, h); bus_rd(8'h2A, mm); bus_rd(8'h2B, l);
    v = {h[1:0], mm, l};
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [17:0] v;
    logic [2:0] m;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk("R1 rdata after reset", rdata, 0);
    chk("R1 match after reset", match, 0);
    bus_rd(8'h20, d); chk("R1 select resets to 00", d, 0);
    for (int s = 0; s < 3; s++) begin
      get_cmp(2'(s), v); chk("R1 comparator resets to 0", v, 0);
    end

    bus_wr(8'h20, 8'hFD); bus_rd(8'h20, d); chk("R2 control readback pads zero", d, 8'h01);

    set_cmp(2'd0, 18'h31234);
    set_cmp(2'd1, 18'h1ABCD);
    set_cmp(2'd2, 18'h25678);
    bus_wr(8'h20, 8'h00); bus_rd(8'h29, d); chk("R5 high reg upper bits zero", d, 8'h03);
    get_cmp(2'd0, v); chk("R3 bank A", v, 18'h31234);
    get_cmp(2'd1, v); chk("R3 bank B", v, 18'h1ABCD);
    get_cmp(2'd2, v); chk("R3 bank C", v, 18'h25678);
    bus_wr(8'h20, 8'h01);
    bus_rd(8'h2A, d); chk("R6 mid reg bits 15:8", d, 8'hAB);
    bus_rd(8'h2B, d); chk("R6 low reg bits 7:0", d, 8'hCD);

    bus_wr(8'h20, 8'h03);
    bus_rd(8'h2A, d); chk("R4 empty bank reads zero", d, 0);
    bus_wr(8'h29, 8'h00); bus_wr(8'h2A, 8'h55); bus_wr(8'h2B, 8'h66);
    get_cmp(2'd0, v); chk("R4 empty bank write ignored A", v, 18'h31234);
    get_cmp(2'd1, v); chk("R4 empty bank write ignored B", v, 18'h1ABCD);
    get_cmp(2'd2, v); chk("R4 empty bank write ignored C", v, 18'h25678);

    armed = 1;
    bus_wr(8'h20, 8'h01); bus_wr(8'h2A, 8'h77); bus_wr(8'h29, 8'h02);
    bus_rd(8'h20, d); chk("R2 select writable while armed", d, 8'h01);
    armed = 0;
    get_cmp(2'd1, v); chk("R7 armed write ignored", v, 18'h1ABCD);

    bus_wr(8'h20, 8'h00);
    bus_wr(8'h28, 8'hFF); bus_wr(8'h2C, 8'hFF); bus_wr(8'h2F, 8'hFF);
    bus_rd(8'h28, d); chk("R8 offset 28 reads zero", d, 0);
    bus_rd(8'h2E, d); chk("R8 offset 2E reads zero", d, 0);
    get_cmp(2'd0, v); chk("R8 reserved writes no effect", v, 18'h31234);

    bus_wr(8'h20, 8'h02); bus_rd(8'h2B, d);
    repeat (4) @(posedge clk); #2;
    chk("R9 rdata held between reads", rdata, 8'h78);

    cpu(18'h31234, 1, m); chk("R10 match A", m, 3'b001);
    @(posedge clk); #2; chk("R10 one-cycle pulse", match, 0);
    cpu(18'h11234, 1, m); chk("R10 bit17 differs no match", m, 0);
    set_cmp(2'd2, 18'h31234);
    cpu(18'h31234, 1, m); chk("R10 A and C both match", m, 3'b101);
    cpu(18'h1ABCD, 0, m); chk("R11 no match without valid", m, 0);

    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #2;
      en = ($urandom % 2) == 0;
      we = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: addr = 8'h20;
        1: addr = 8'h29 + 8'($urandom % 3);
        2: addr = 8'h28 + 8'($urandom % 8);
        default: addr = 8'($urandom);
      endcase
      wdata = 8'($urandom);
      armed = ($urandom % 4) == 0;
      cpu_valid = ($urandom % 2) == 0;
      cpu_addr = (($urandom % 2) == 0) ? m_addr[$urandom % 3] : 18'($urandom);
    end
    @(posedge clk); #2; en = 0; we = 0; cpu_valid = 0; armed = 0;
    repeat (3) @(posedge clk);
    summary();
  end
endmodule